// File: doc/BRIEF.md
# ADC Parallel Read Port Controller

This block is the control logic that sits between a microprocessor-style parallel read bus and the conversion engine of an 8-bit, 8-channel sampling converter. The host selects the converter with an active-low chip select and reads it with an active-low read strobe. The read strobe also picks one of eight analog channels. The block turns these bus accesses into one-cycle start requests for the engine and captures each result the engine reports. It drives that result onto a data bus that has an explicit enable. It also drives two status outputs: a ready line modelled as a pull-low enable, and an active-low interrupt.

Two read protocols are selected by `modeWait`. With `modeWait` high, a single access is held open by the host until the result is ready. The access starts the conversion, the ready line stalls the host, and the fresh result is driven within that same access. With `modeWait` low, every access immediately returns the result of the earlier conversion. The channel is captured when the read ends, and the next conversion starts at that point.

The strobes are brought into the clock domain by a synchronizer of `SYNC_STAGES` flops, and edges are found by comparing registered samples. Every strobe-driven output therefore changes on the clock edge `SYNC_STAGES + 1` after the strobe moves. `convDone` and `convResult` come from the engine in the same clock domain and are used without a synchronizer.

Top module: `adc_read_port`

## Requirements
- R1: After reset, the outputs are `dataOe`=0, `dataOut`=0x00, `intN`=1, `rdyPullLow`=0 and `startPulse`=0. The result register holds 0x00, so a first read in non-wait mode returns 0x00.
- R2: A conversion is requested only while `csN` and `rdN` are both low. In wait mode, `startPulse` is high for exactly one cycle, `SYNC_STAGES+1` edges after the access opens. Chip select alone never produces a start.
- R3: In wait mode, `dataOe` stays 0 and `dataOut` stays 0x00 during an access until `convDone`. On the next clock edge, `dataOe` becomes 1 with the new result on `dataOut`. It stays that way until the access closes.
- R4: In wait mode, `rdyPullLow` becomes 1 `SYNC_STAGES+1` edges after `csN` falls. It returns to 0 on the same edge that the result appears, or after `csN` rises. It is never 1 while `dataOe` is 1.
- R5: In wait mode, `startChan` follows `chanIn` on every cycle of an open access, one edge later.
- R6: `intN` goes to 0 on the edge after `convDone`. It returns to 1 `SYNC_STAGES+1` edges after either `csN` or `rdN` rises and ends the access.
- R7: In non-wait mode, an access drives `dataOe`=1 with the previously stored result at once. It does not wait for a conversion.
- R8: In non-wait mode, the channel is captured when the read ends. `startPulse` is then high for one cycle with that channel on `startChan`, and `startChan` keeps that value afterwards.
- R9: In non-wait mode, `rdyPullLow` is never 1.
- R10: The result register loads only on `convDone`. Reads with no conversion in between return the same value.
- R11: When `convDone` arrives on the same cycle that the end of an access is detected, `intN` goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low, asynchronous |
| rdN | input | 1 | Read strobe, active low, asynchronous |
| chanIn | input | CHAN_W | Channel address from the host |
| modeWait | input | 1 | 1 = wait-state protocol, 0 = non-wait protocol |
| convDone | input | 1 | One-cycle end-of-conversion pulse from the engine |
| convResult | input | DATA_W | Conversion result, valid with convDone |
| startPulse | output | 1 | One-cycle conversion start request |
| startChan | output | CHAN_W | Channel for the engine to convert |
| dataOut | output | DATA_W | Data bus value, 0 while not enabled |
| dataOe | output | 1 | Data bus drive enable |
| rdyPullLow | output | 1 | Ready line pull-low enable |
| intN | output | 1 | Interrupt, active low |

## Verification
In wait mode, a held access with a mid-access channel change shows whether the channel is tracked continuously or only captured at the start. A chip select with no read separates the ready stall from the conversion start. In non-wait mode, back-to-back reads with and without an intervening conversion show whether the bus returns the stored previous result and whether the channel is captured at read end. A done pulse placed on the exact cycle the access end is detected shows which of the two events the interrupt favours.

// File: rtl/adc_read_pkg.sv
package adc_read_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic fireStart;   // issue a start request this cycle
    logic loadChan;    // capture chanIn into the channel register
    logic loadResult;  // capture convResult into the result register
    logic driveBus;    // registered bus enable
  } dpStrobe_t;

endpackage

// File: rtl/adc_read_sync.sv
module adc_read_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= RESET_VAL;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= RESET_VAL;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
  import adc_read_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csS,
  input  logic      rdS,
  input  logic      modeWait,
  input  logic      convDone,
  output dpStrobe_t strobe,
  output logic      rdyPullLow,
  output logic      intN
);

  logic csQ, activeQ, freshQ, oeQ, rdyQ, intQ;
  logic active, accRise, accEnd, csFall;
  logic freshNext, oeNext, rdyNext, intNext;

  // Access detection from registered samples
  assign active  = ~csS & ~rdS;
  assign accRise = active & ~activeQ;
  assign accEnd  = ~active & activeQ;
  assign csFall  = ~csS & csQ;

  always_comb begin
    // Fresh result captured inside the current wait-mode access
    if (!active)                    freshNext = 1'b0;
    else if (modeWait && convDone)  freshNext = 1'b1;
    else                            freshNext = freshQ;

    if (modeWait) oeNext = active & (freshQ | convDone);
    else          oeNext = active;

    if (!modeWait || csS)  rdyNext = 1'b0;
    else if (convDone)     rdyNext = 1'b0;
    else if (csFall)       rdyNext = 1'b1;
    else                   rdyNext = rdyQ;

    // A completed conversion takes priority over the end of an access
    if (convDone)     intNext = 1'b0;
    else if (accEnd)  intNext = 1'b1;
    else              intNext = intQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ     <= 1'b1;
      activeQ <= 1'b0;
      freshQ  <= 1'b0;
      oeQ     <= 1'b0;
      rdyQ    <= 1'b0;
      intQ    <= 1'b1;
    end else begin
      csQ     <= csS;
      activeQ <= active;
      freshQ  <= freshNext;
      oeQ     <= oeNext;
      rdyQ    <= rdyNext;
      intQ    <= intNext;
    end
  end

  always_comb begin
    strobe.fireStart  = modeWait ? accRise : accEnd;
    strobe.loadChan   = modeWait ? active  : accEnd;
    strobe.loadResult = convDone;
    strobe.driveBus   = oeQ;
  end

  assign rdyPullLow = rdyQ;
  assign intN       = intQ;

endmodule

// File: rtl/adc_read_dp.sv
module adc_read_dp
  import adc_read_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CHAN_W-1:0] chanIn,
  input  logic [DATA_W-1:0] convResult,
  output logic              startPulse,
  output logic [CHAN_W-1:0] startChan,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  logic [DATA_W-1:0] resultReg;
  logic [CHAN_W-1:0] chanReg;
  logic              startQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg <= '0;
      chanReg   <= '0;
      startQ    <= 1'b0;
    end else begin
      if (strobe.loadResult) resultReg <= convResult;
      if (strobe.loadChan)   chanReg   <= chanIn;
      startQ <= strobe.fireStart;
    end
  end

  assign startPulse = startQ;
  assign startChan  = chanReg;
  assign dataOe     = strobe.driveBus;
  assign dataOut    = strobe.driveBus ? resultReg : '0;

endmodule

// File: rtl/adc_read_port.sv
module adc_read_port
  import adc_read_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHAN_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic [CHAN_W-1:0] chanIn,
  input  logic              modeWait,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convResult,
  output logic              startPulse,
  output logic [CHAN_W-1:0] startChan,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              rdyPullLow,
  output logic              intN
);

  localparam int STROBE_N = 2;

  logic [STROBE_N-1:0] strobeSync;
  dpStrobe_t           dpStrobe;

  adc_read_sync #(
    .WIDTH(STROBE_N),
    .STAGES(SYNC_STAGES),
    .RESET_VAL('1)
  ) u_sync (
    .clk(clk),
    .rstN(rstN),
    .asyncIn({csN, rdN}),
    .syncOut(strobeSync)
  );

  adc_read_ctrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .csS(strobeSync[1]),
    .rdS(strobeSync[0]),
    .modeWait(modeWait),
    .convDone(convDone),
    .strobe(dpStrobe),
    .rdyPullLow(rdyPullLow),
    .intN(intN)
  );

  adc_read_dp #(
    .DATA_W(DATA_W),
    .CHAN_W(CHAN_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(dpStrobe),
    .chanIn(chanIn),
    .convResult(convResult),
    .startPulse(startPulse),
    .startChan(startChan),
    .dataOut(dataOut),
    .dataOe(dataOe)
  );

endmodule

// File: rtl/adc_read_port_chk.sv
module adc_read_port_chk #(
  parameter int DATA_W = 8,
  parameter int CHAN_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeWait,
  input logic              convDone,
  input logic              startPulse,
  input logic [CHAN_W-1:0] startChan,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic              rdyPullLow,
  input logic              intN
);

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  assert_rdy_released_nowait_R9: assert property (@(posedge clk) disable iff (!rstN)
    !modeWait |=> !rdyPullLow);

  assert_done_lowers_int_R6: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !intN);

  assert_rdy_oe_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(rdyPullLow && dataOe));

  assert_fresh_has_int_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeWait && dataOe) |-> !intN);

endmodule

bind adc_read_port adc_read_port_chk #(
  .DATA_W(DATA_W),
  .CHAN_W(CHAN_W)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .modeWait(modeWait),
  .convDone(convDone),
  .startPulse(startPulse),
  .startChan(startChan),
  .dataOut(dataOut),
  .dataOe(dataOe),
  .rdyPullLow(rdyPullLow),
  .intN(intN)
);

// File: tb/adc_read_port_bench.sv
module adc_read_port_bench;

  localparam int DATA_W = 8;
  localparam int CHAN_W = 3;
  localparam int LAT = 3; // SYNC_STAGES + 1 edges

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              csN = 1'b1;
  logic              rdN = 1'b1;
  logic [CHAN_W-1:0] chanIn = '0;
  logic              modeWait = 1'b0;
  logic              convDone = 1'b0;
  logic [DATA_W-1:0] convResult = '0;
  logic              startPulse;
  logic [CHAN_W-1:0] startChan;
  logic [DATA_W-1:0] dataOut;
  logic              dataOe;
  logic              rdyPullLow;
  logic              intN;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  adc_read_port #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .SYNC_STAGES(2)) u_adc_read_port (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .chanIn(chanIn),
    .modeWait(modeWait), .convDone(convDone), .convResult(convResult),
    .startPulse(startPulse), .startChan(startChan), .dataOut(dataOut),
    .dataOe(dataOe), .rdyPullLow(rdyPullLow), .intN(intN)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseDone(input logic [DATA_W-1:0] val);
    convResult = val;
    convDone = 1'b1;
    @(negedge clk);
    convDone = 1'b0;
  endtask

  task automatic testReset();
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    chk("R1 dataOe", dataOe, 0);
    chk("R1 dataOut", dataOut, 0);
    chk("R1 intN", intN, 1);
    chk("R1 rdyPullLow", rdyPullLow, 0);
    chk("R1 startPulse", startPulse, 0);
  endtask

  task automatic testFirstReadNoWait();
    modeWait = 1'b0; chanIn = 3'd1; csN = 1'b0; rdN = 1'b0;
    waitN(LAT);
    chk("R7 dataOe at read", dataOe, 1);
    chk("R1 reset result on bus", dataOut, 8'h00);
    chk("R9 rdy in non-wait", rdyPullLow, 0);
    chk("R8 no start during read", startPulse, 0);
    csN = 1'b1; rdN = 1'b1;
    waitN(LAT);
    chk("R8 start at read end", startPulse, 1);
    chk("R8 latched channel", startChan, 1);
    chk("R7 bus released", dataOe, 0);
    waitN(1);
    chk("R8 start one cycle", startPulse, 0);
  endtask

  task automatic testCsOnly();
    int starts = 0;
    modeWait = 1'b1; csN = 1'b0;
    waitN(LAT);
    chk("R4 rdy pulled on cs fall", rdyPullLow, 1);
    for (int i = 0; i < 5; i++) begin
      if (startPulse) starts++;
      waitN(1);
    end
    chk("R2 no start with cs only", starts, 0);
    csN = 1'b1;
    waitN(LAT - 1);
    chk("R4 rdy held before cs seen", rdyPullLow, 1);
    waitN(1);
    chk("R4 rdy released on cs rise", rdyPullLow, 0);
  endtask

  task automatic testWaitRead();
    modeWait = 1'b1; chanIn = 3'd5; csN = 1'b0; rdN = 1'b0;
    waitN(LAT);
    chk("R2 start at access open", startPulse, 1);
    chk("R5 channel at start", startChan, 5);
    chk("R4 rdy low during conversion", rdyPullLow, 1);
    chk("R3 bus off before done", dataOe, 0);
    chk("R3 bus zero before done", dataOut, 0);
    chanIn = 3'd6;
    waitN(1);
    chk("R2 start one cycle", startPulse, 0);
    chk("R5 channel tracked", startChan, 6);
    waitN(4);
    chk("R3 bus still off", dataOe, 0);
    pulseDone(8'hA5);
    chk("R3 bus on after done", dataOe, 1);
    chk("R3 new result", dataOut, 8'hA5);
    chk("R4 rdy released with result", rdyPullLow, 0);
    chk("R6 int low after done", intN, 0);
    rdN = 1'b1;
    waitN(LAT - 1);
    chk("R6 int held before rd seen", intN, 0);
    chk("R3 bus held until access end", dataOe, 1);
    waitN(1);
    chk("R6 int high after rd rise", intN, 1);
    chk("R3 bus off after access", dataOe, 0);
    csN = 1'b1;
    waitN(LAT + 1);
  endtask

  task automatic testNoWaitCycle();
    modeWait = 1'b0; chanIn = 3'd3; csN = 1'b0; rdN = 1'b0;
    waitN(LAT);
    chk("R7 previous result at once", dataOut, 8'hA5);
    chk("R9 rdy never pulled", rdyPullLow, 0);
    chanIn = 3'd2;
    waitN(1);
    csN = 1'b1; rdN = 1'b1;
    waitN(LAT);
    chk("R8 start at end", startPulse, 1);
    chk("R8 channel at rd rise", startChan, 2);
    chanIn = 3'd7;
    waitN(2);
    chk("R8 channel kept", startChan, 2);
    pulseDone(8'h3C);
    chk("R6 int low at done", intN, 0);
    chk("R7 bus off between reads", dataOut, 0);
    chanIn = 3'd4; csN = 1'b0; rdN = 1'b0;
    waitN(LAT);
    chk("R7 second read result", dataOut, 8'h3C);
    chk("R6 int low during read", intN, 0);
    csN = 1'b1; rdN = 1'b1;
    waitN(LAT - 1);
    chk("R6 int held", intN, 0);
    waitN(1);
    chk("R6 int high after read", intN, 1);
    chk("R8 second start channel", startChan, 4);
    waitN(2);
  endtask

  task automatic testReread();
    modeWait = 1'b0; csN = 1'b0; rdN = 1'b0;
    waitN(LAT);
    chk("R10 value unchanged by read", dataOut, 8'h3C);
    csN = 1'b1; rdN = 1'b1;
    waitN(LAT + 2);
  endtask

  task automatic testDoneAtEnd();
    modeWait = 1'b0; csN = 1'b0; rdN = 1'b0;
    waitN(LAT);
    csN = 1'b1; rdN = 1'b1;
    waitN(LAT - 1);
    pulseDone(8'h5A);
    chk("R11 done wins over access end", intN, 0);
    waitN(2);
    chk("R11 int stays low", intN, 0);
    csN = 1'b0; rdN = 1'b0;
    waitN(LAT);
    chk("R10 stored new result", dataOut, 8'h5A);
    csN = 1'b1; rdN = 1'b1;
    waitN(LAT + 2);
  endtask

  initial begin
    testReset();
    testFirstReadNoWait();
    testCsOnly();
    testWaitRead();
    testNoWaitCycle();
    testReread();
    testDoneAtEnd();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule